// File: doc/BRIEF.md
# Count-Based Transaction Commit Checker

This block lets a persistent log decide afterwards whether a transaction finished, without writing a separate commit marker. Every log block gets a tag pair: a transaction identifier and a count field. Only the final block of a transaction carries a non-zero count, equal to the number of blocks in that transaction. Every other block carries zero. Because nothing has to be written after the other blocks, the blocks of one transaction may reach persistent storage in any order.

The write side takes a stream of log-block writes, one transaction at a time, with an end flag on the last block. One cycle later it presents the same identifier together with the count field that the block must carry. The recovery side takes a scan of tagged blocks in any order. For each identifier it keeps the count recorded in the tags and a running tally of the blocks observed. When the end-of-log strobe arrives, it reports a verdict for every identifier it saw, one at a time over a valid/ready handshake. It then clears its table, ready for the next scan.

Top module: `cbc_top`

## Requirements
- R1: One cycle after `wr_valid` is sampled with `wr_end` low, `tag_valid` is 1, `tag_id` equals the sampled `wr_id` and `tag_cnt` is 0.
- R2: One cycle after `wr_valid` is sampled with `wr_end` high, `tag_cnt` equals the number of blocks in that transaction, including the end block. The next block then starts a fresh transaction.
- R3: A scanned identifier with exactly one non-zero count, where that count equals the number of blocks scanned with that identifier, is reported with `res_commit`=1 and `res_corrupt`=0, whatever position the count block had in the scan.
- R4: A scanned identifier whose single non-zero count differs from its scanned block total is reported with `res_commit`=0.
- R5: A scanned identifier whose blocks all carry count 0 is reported with `res_commit`=0.
- R6: A scanned identifier that received two or more non-zero counts is reported with `res_corrupt`=1 and `res_commit`=0, even when the count equals the block total.
- R7: The table holds 8 identifiers (3-bit ID) with 8-bit counts. An identifier that receives more than 255 scanned blocks is reported with `res_commit`=0. An identifier that receives exactly 255 blocks and a count of 255 is reported as committed.
- R8: After `scan_eol`, one result is produced for each identifier that received at least one scanned block, in strictly ascending `res_id` order. Identifiers with no blocks produce no result. The first result can appear one cycle after the strobe.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_id`, `res_commit` and `res_corrupt` hold their values into the next cycle.
- R10: Scan blocks presented while results are still being reported are ignored. After the last result, the table is empty, so the next scan starts from zero for every identifier.
- R11: After reset, `tag_valid` and `res_valid` are 0, and a cycle with `wr_valid` low is followed by `tag_valid` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A log block is being written |
| wr_id | input | 3 | Transaction identifier of the written block |
| wr_end | input | 1 | The written block is the last of its transaction |
| tag_valid | output | 1 | Tag pair below is valid |
| tag_id | output | 3 | Identifier to store with the block |
| tag_cnt | output | 8 | Count to store with the block (0, or the block total on the end block) |
| scan_valid | input | 1 | A tagged block is presented from the log scan |
| scan_id | input | 3 | Identifier of the scanned block |
| scan_cnt | input | 8 | Count field of the scanned block |
| scan_eol | input | 1 | End-of-log strobe that starts the reporting |
| res_ready | input | 1 | Consumer accepts the current result |
| res_valid | output | 1 | A verdict is offered |
| res_id | output | 3 | Identifier the verdict belongs to |
| res_commit | output | 1 | 1 when the transaction is committed |
| res_corrupt | output | 1 | 1 when more than one non-zero count was seen |

## Verification
Some properties can be checked on every cycle: the tag format on both kinds of write, the result held steady under backpressure, ascending identifiers between accepted results, a corrupt verdict never also marked committed, and an idle write cycle producing no tag. Other behaviours need whole scenarios, and only the bench scenarios can show them: the verdict rules (matching totals in any block order, mismatch, missing count block, duplicate count), the 255/256-block boundary, the omission of identifiers that were never scanned, and the clearing of the table between scans, which includes the blocks ignored while reporting was in progress.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    parameter int unsigned DEF_ID_W  = 3;
    parameter int unsigned DEF_CNT_W = 8;

    typedef enum logic {
        PH_SCAN = 1'b0,
        PH_EMIT = 1'b1
    } phase_e;
endpackage

// File: rtl/cbc_tagger.sv
module cbc_tagger #(
    parameter int unsigned ID_W  = cbc_pkg::DEF_ID_W,
    parameter int unsigned CNT_W = cbc_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ID_W-1:0]  in_id,
    input  logic             in_end,
    output logic             out_valid,
    output logic [ID_W-1:0]  out_id,
    output logic [CNT_W-1:0] out_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             vld;
        logic [ID_W-1:0]  id;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] run;   // blocks seen so far in the open transaction
    } tag_st_t;

    tag_st_t s_d, s_q;
    logic [CNT_W:0] total;

    always_comb begin
        s_d     = s_q;
        total   = {1'b0, s_q.run} + {{CNT_W{1'b0}}, 1'b1};
        s_d.vld = in_valid;
        s_d.cnt = '0;
        if (in_valid) begin
            s_d.id = in_id;
            if (in_end) begin
                // a total that does not fit the field is written as 0,
                // so recovery can never declare it committed
                s_d.cnt = total[CNT_W] ? '0 : total[CNT_W-1:0];
                s_d.run = '0;
            end else begin
                s_d.run = (s_q.run == CNT_MAX) ? CNT_MAX : total[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_id    = s_q.id;
    assign out_cnt   = s_q.cnt;
endmodule

// File: rtl/cbc_entry.sv
module cbc_entry #(
    parameter int unsigned CNT_W = cbc_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [CNT_W-1:0] hit_cnt,
    input  logic             clr,
    output logic             present,
    output logic             committed,
    output logic             corrupt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             pres;
        logic             has_rec;
        logic             dup;
        logic             ovf;
        logic [CNT_W-1:0] rec;
        logic [CNT_W-1:0] seen;
    } ent_st_t;

    ent_st_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (clr) begin
            e_d = '0;
        end else if (hit) begin
            e_d.pres = 1'b1;
            if (e_q.seen == CNT_MAX) e_d.ovf  = 1'b1;
            else                     e_d.seen = e_q.seen + 1'b1;
            if (hit_cnt != '0) begin
                if (e_q.has_rec) begin
                    e_d.dup = 1'b1;
                end else begin
                    e_d.has_rec = 1'b1;
                    e_d.rec     = hit_cnt;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign present   = e_q.pres;
    assign corrupt   = e_q.dup;
    assign committed = e_q.pres & e_q.has_rec & ~e_q.dup & ~e_q.ovf
                     & (e_q.rec == e_q.seen);
endmodule

// File: rtl/cbc_emitter.sv
module cbc_emitter #(
    parameter int unsigned ID_W = cbc_pkg::DEF_ID_W,
    localparam int unsigned N   = 1 << ID_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eol,
    input  logic [N-1:0]    present,
    input  logic [N-1:0]    committed,
    input  logic [N-1:0]    corrupt,
    input  logic            res_ready,
    output logic            res_valid,
    output logic [ID_W-1:0] res_id,
    output logic            res_commit,
    output logic            res_corrupt,
    output logic            scan_en,
    output logic            clr
);
    import cbc_pkg::*;

    localparam logic [ID_W-1:0] LAST_ID = {ID_W{1'b1}};

    typedef struct packed {
        phase_e          phase;
        logic [ID_W-1:0] idx;
    } emit_st_t;

    emit_st_t m_d, m_q;
    logic     adv;

    always_comb begin
        m_d = m_q;
        clr = 1'b0;
        adv = 1'b0;
        if (m_q.phase == PH_SCAN) begin
            if (eol) begin
                m_d.phase = PH_EMIT;
                m_d.idx   = '0;
            end
        end else begin
            // walk past empty slots; wait for ready on filled ones
            adv = ~present[m_q.idx] | res_ready;
            if (adv) begin
                if (m_q.idx == LAST_ID) begin
                    m_d.phase = PH_SCAN;
                    clr       = 1'b1;
                end else begin
                    m_d.idx = m_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '{phase: PH_SCAN, idx: '0};
        else        m_q <= m_d;
    end

    assign scan_en     = (m_q.phase == PH_SCAN);
    assign res_valid   = (m_q.phase == PH_EMIT) & present[m_q.idx];
    assign res_id      = m_q.idx;
    assign res_commit  = committed[m_q.idx];
    assign res_corrupt = corrupt[m_q.idx];
endmodule

// File: rtl/cbc_top.sv
module cbc_top #(
    parameter int unsigned ID_W  = cbc_pkg::DEF_ID_W,
    parameter int unsigned CNT_W = cbc_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [ID_W-1:0]  wr_id,
    input  logic             wr_end,
    output logic             tag_valid,
    output logic [ID_W-1:0]  tag_id,
    output logic [CNT_W-1:0] tag_cnt,
    input  logic             scan_valid,
    input  logic [ID_W-1:0]  scan_id,
    input  logic [CNT_W-1:0] scan_cnt,
    input  logic             scan_eol,
    input  logic             res_ready,
    output logic             res_valid,
    output logic [ID_W-1:0]  res_id,
    output logic             res_commit,
    output logic             res_corrupt
);
    localparam int unsigned N = 1 << ID_W;

    logic [N-1:0] present, committed, corrupt;
    logic         scan_en, clr;

    cbc_tagger #(.ID_W(ID_W), .CNT_W(CNT_W)) u_tagger (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (wr_valid),
        .in_id    (wr_id),
        .in_end   (wr_end),
        .out_valid(tag_valid),
        .out_id   (tag_id),
        .out_cnt  (tag_cnt)
    );

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic hit;
        assign hit = scan_valid & scan_en & (scan_id == ID_W'(g));
        cbc_entry #(.CNT_W(CNT_W)) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit),
            .hit_cnt  (scan_cnt),
            .clr      (clr),
            .present  (present[g]),
            .committed(committed[g]),
            .corrupt  (corrupt[g])
        );
    end

    cbc_emitter #(.ID_W(ID_W)) u_emitter (
        .clk        (clk),
        .rst_n      (rst_n),
        .eol        (scan_eol),
        .present    (present),
        .committed  (committed),
        .corrupt    (corrupt),
        .res_ready  (res_ready),
        .res_valid  (res_valid),
        .res_id     (res_id),
        .res_commit (res_commit),
        .res_corrupt(res_corrupt),
        .scan_en    (scan_en),
        .clr        (clr)
    );
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
    parameter int unsigned ID_W  = cbc_pkg::DEF_ID_W,
    parameter int unsigned CNT_W = cbc_pkg::DEF_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic [ID_W-1:0]  wr_id,
    input logic             wr_end,
    input logic             tag_valid,
    input logic [ID_W-1:0]  tag_id,
    input logic [CNT_W-1:0] tag_cnt,
    input logic             scan_valid,
    input logic [ID_W-1:0]  scan_id,
    input logic [CNT_W-1:0] scan_cnt,
    input logic             scan_eol,
    input logic             res_ready,
    input logic             res_valid,
    input logic [ID_W-1:0]  res_id,
    input logic             res_commit,
    input logic             res_corrupt
);
    // R1
    mid_block_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_end) |=> (tag_valid && tag_cnt == '0 && tag_id == $past(wr_id)));

    // R2
    end_block_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_end) |=> (tag_valid && tag_id == $past(wr_id)));

    // R11
    idle_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !tag_valid);

    // R6
    corrupt_not_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_corrupt) |-> !res_commit);

    // R8
    ascending_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready) |=> (!res_valid || res_id > $past(res_id)));

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_id)
                                       && $stable(res_commit) && $stable(res_corrupt)));
endmodule

bind cbc_top cbc_checker #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/cbc_top_bench.sv
module cbc_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0, wr_end = 1'b0;
    logic [2:0] wr_id = '0;
    logic       tag_valid;
    logic [2:0] tag_id;
    logic [7:0] tag_cnt;
    logic       scan_valid = 1'b0, scan_eol = 1'b0, res_ready = 1'b0;
    logic [2:0] scan_id = '0;
    logic [7:0] scan_cnt = '0;
    logic       res_valid, res_commit, res_corrupt;
    logic [2:0] res_id;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // behavioural model state
    int seen [8];
    int rec  [8];
    int nrec [8];
    int exp_q[$];
    int wr_run = 0;

    always #2.5 clk = ~clk;

    cbc_top u_cbc_top (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_id(wr_id), .wr_end(wr_end),
        .tag_valid(tag_valid), .tag_id(tag_id), .tag_cnt(tag_cnt),
        .scan_valid(scan_valid), .scan_id(scan_id), .scan_cnt(scan_cnt),
        .scan_eol(scan_eol), .res_ready(res_ready),
        .res_valid(res_valid), .res_id(res_id),
        .res_commit(res_commit), .res_corrupt(res_corrupt)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cycles);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_model();
        for (int i = 0; i < 8; i++) begin
            seen[i] = 0; rec[i] = 0; nrec[i] = 0;
        end
    endtask

    task automatic write_blk(input int id, input bit last);
        int exp;
        if (last) begin exp = wr_run + 1; wr_run = 0; end
        else      begin exp = 0; wr_run++; end
        wr_valid = 1'b1; wr_id = 3'(id); wr_end = last;
        step();
        wr_valid = 1'b0; wr_end = 1'b0;
        chk(tag_valid == 1'b1, "R1", "tag_valid", int'(tag_valid), 1);
        chk(tag_id == 3'(id), "R1", "tag_id", int'(tag_id), id);
        chk(tag_cnt == 8'(exp), last ? "R2" : "R1", "tag_cnt", int'(tag_cnt), exp);
    endtask

    task automatic scan_blk(input int id, input int cnt);
        seen[id]++;
        if (cnt != 0) begin rec[id] = cnt; nrec[id]++; end
        scan_valid = 1'b1; scan_id = 3'(id); scan_cnt = 8'(cnt);
        step();
        scan_valid = 1'b0; scan_cnt = '0;
    endtask

    // drains results; optionally injects ignored scan blocks (R10)
    task automatic end_and_drain(input bit inject);
        int prev_valid = 0, prev_id = 0, guard = 0, k = 0;
        for (int i = 0; i < 8; i++)
            if (seen[i] > 0) begin
                bit c, d;
                d = (nrec[i] > 1);
                c = (nrec[i] == 1) && (rec[i] == seen[i]) && (seen[i] <= 255);
                exp_q.push_back(i * 4 + int'(c) * 2 + int'(d));
            end
        scan_eol = 1'b1;
        step();
        scan_eol = 1'b0;
        while (exp_q.size() > 0 && guard < 64) begin
            res_ready = (k % 3) != 1;
            if (inject && k < 2) begin
                scan_valid = 1'b1; scan_id = 3'd0; scan_cnt = 8'd0;
            end else begin
                scan_valid = 1'b0;
            end
            if (prev_valid == 1)
                chk(res_valid && int'(res_id) == prev_id, "R9", "held result id",
                    int'(res_id), prev_id);
            prev_valid = 0;
            if (res_valid) begin
                int e = exp_q[0];
                if (res_ready) begin
                    void'(exp_q.pop_front());
                    chk(int'(res_id) == e / 4, "R8", "result id", int'(res_id), e / 4);
                    chk(res_commit == e[1], "R3", "res_commit", int'(res_commit), e[1]);
                    chk(res_corrupt == e[0], "R6", "res_corrupt", int'(res_corrupt), e[0]);
                end else begin
                    prev_valid = 1; prev_id = int'(res_id);
                end
            end
            step();
            k++; guard++;
        end
        scan_valid = 1'b0;
        res_ready = 1'b1;
        chk(exp_q.size() == 0, "R8", "results missing", exp_q.size(), 0);
        exp_q.delete();
        for (int i = 0; i < 10; i++) begin
            chk(!res_valid, "R8", "extra result", int'(res_valid), 0);
            step();
        end
        res_ready = 1'b0;
        clear_model();
    endtask

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        chk(!tag_valid, "R11", "tag_valid in reset", int'(tag_valid), 0);
        chk(!res_valid, "R11", "res_valid in reset", int'(res_valid), 0);
        rst_n = 1'b1;
        step();
        chk(!tag_valid, "R11", "tag_valid after reset", int'(tag_valid), 0);
        chk(!res_valid, "R11", "res_valid after reset", int'(res_valid), 0);

        // write side: R1, R2
        write_blk(2, 0); write_blk(2, 0); write_blk(2, 1);
        write_blk(5, 1);
        write_blk(0, 0); write_blk(0, 1);
        step();
        chk(!tag_valid, "R11", "tag_valid idle", int'(tag_valid), 0);

        // scan 1: R3 (count block in middle), R4, R5, R6, R3 single
        scan_blk(1, 0); scan_blk(3, 3); scan_blk(1, 3); scan_blk(4, 0);
        scan_blk(6, 2); scan_blk(1, 0); scan_blk(3, 0); scan_blk(6, 2);
        scan_blk(4, 0); scan_blk(7, 1);
        end_and_drain(1'b1);   // injects id 0 blocks during reporting (R10)

        // scan 2: R10 table cleared and injected blocks ignored
        scan_blk(0, 1);
        end_and_drain(1'b0);

        // scan 3: R7 boundary 255 committed, 256 rejected
        for (int i = 0; i < 255; i++) scan_blk(2, (i == 254) ? 255 : 0);
        for (int i = 0; i < 256; i++) scan_blk(5, (i == 0) ? 255 : 0);
        end_and_drain(1'b0);

        finish_run();
    end
endmodule